// File: doc/BRIEF.md
# Match-Aligned Serial Byte Receiver

This block turns a serial link bit stream into bytes for a receive FIFO. One bit is taken on each clock where the bit strobe is high, and bits are packed into bytes with the first received bit landing in bit 0. In free-running mode every group of eight bits counted from the start of reception is written out. In search mode nothing is written until a programmable match byte turns up in the stream. From that point the byte grid is aligned to the match, and the match byte itself is the first byte written.

The search has two forms. A sliding search tests the last eight bits on every strobe. An octet search tests only at octet boundaries, which are counted from the first strobe after reception starts. When the match is found, the block records the offset of the match against that boundary. It can also raise a one-clock interrupt. A receiver reset discards all progress and starts the search again.

The control is a three-state machine. The states are IDLE (receiver off or being reset), HUNT (searching for the match byte) and PASS (assembling aligned bytes). The transitions are:
- START_HUNT: IDLE→HUNT when enabled with search on.
- START_PASS: IDLE→PASS when enabled with search off.
- MATCH: HUNT→PASS when the match byte is found.
- STOP: any state→IDLE when the enable drops or the receiver reset is high.

Top module: `mrx_align_rx`

## Requirements
- R1: Bits are packed least significant first: the first bit of each byte appears at bit 0 of `wr_data`, and the eighth bit appears at bit 7.
- R2: With `match_en`=0, the machine leaves IDLE one clock after `rx_en` goes high. Every eighth strobe counted from there completes a byte. That byte appears on `wr_data` with `wr_en` high for one clock, on the clock after the eighth strobe.
- R3: With `match_en`=1 and `octet_only`=0, the last eight bits are compared with `match_byte` on every strobe once eight bits have arrived. On a hit, the match byte is written and every later group of eight strobes is written as a byte.
- R4: With `match_en`=1 and `octet_only`=1, the comparison is made only on strobes whose count since reception started is a multiple of eight.
- R5: In search mode nothing is written before the match. The matched byte is the first byte written.
- R6: While `rx_reset` is high, the block returns to IDLE and clears `match_seen`, `match_ofs` and `overrun`. When `rx_reset` is released, the search starts again and octet boundaries are counted afresh.
- R7: With `match_en`=0, `match_seen` goes to 1 on the clock after the first received bit, and `match_ofs` reads 0.
- R8: With `match_en`=1, `match_ofs` is set on the match to ((k−1) mod 8), where k is the strobe count at which the last match bit arrived. A match aligned to the boundary therefore reads 3'b111.
- R9: `match_irq` is high for exactly one clock, in the clock where `match_seen` rises, and only if `irq_en` is high.
- R10: If a byte completes while `fifo_full` is high, it is not written and `overrun` is set. `overrun` stays set until `rx_reset` or `rst_n` clears it.
- R11: While `rx_en` is low, strobes are ignored, nothing is written and `match_seen` reads 0. After `rst_n`, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe: `bit_in` is valid in this clock |
| bit_in | input | 1 | Serial data bit |
| rx_en | input | 1 | Receiver enable |
| rx_reset | input | 1 | Receiver reset, synchronous; restarts the search |
| match_en | input | 1 | 1 = wait for the match byte before writing |
| octet_only | input | 1 | 1 = compare only on octet boundaries |
| match_byte | input | W | Byte to search for |
| irq_en | input | 1 | Enables `match_irq` |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | W | Byte to write |
| match_seen | output | 1 | Match found (or first bit seen when search is off) |
| match_ofs | output | $clog2(W) | Offset of the match against the octet boundary |
| match_irq | output | 1 | One-clock match interrupt |
| overrun | output | 1 | Sticky: a byte was dropped because the FIFO was full |

## Verification
The bench uses the default W=8, so the offset field is three bits wide. A match can land on any of the eight phases within a few dozen strobes, including the wrap to 3'b111. The hand-built streams put the match byte three bits off the boundary. Under sliding search this gives offset 2. Under octet search the same misaligned copy is refused, and a later aligned copy gives offset 7. A behavioural model built on a bit queue is compared with every output on every clock.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HUNT = 2'd1,
        S_PASS = 2'd2
    } rx_state_t;
endpackage

// File: rtl/mrx_shifter.sv
module mrx_shifter #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 bit_in,
    output logic [W-1:0]         cand,
    output logic [$clog2(W)-1:0] ph,
    output logic                 full
);
    localparam int OW = $clog2(W);
    localparam logic [OW-1:0] FILL_MAX = OW'(W - 1);

    logic [W-1:0]  sh;
    logic [OW-1:0] fill;

    // candidate window: newest bit enters at the top, oldest sits at bit 0
    assign cand = {bit_in, sh[W-1:1]};
    assign full = (fill == FILL_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            ph   <= '0;
            fill <= '0;
        end else if (clr) begin
            sh   <= '0;
            ph   <= '0;
            fill <= '0;
        end else if (step) begin
            sh   <= cand;
            ph   <= ph + 1'b1;
            fill <= full ? fill : fill + 1'b1;
        end
    end
endmodule

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
    import mrx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 rx_en,
    input  logic                 rx_reset,
    input  logic                 match_en,
    input  logic                 octet_only,
    input  logic                 irq_en,
    input  logic                 fifo_full,
    input  logic [W-1:0]         match_byte,
    input  logic [W-1:0]         cand,
    input  logic [$clog2(W)-1:0] ph,
    input  logic                 full,
    output logic                 run,
    output logic                 wr_en,
    output logic [W-1:0]         wr_data,
    output logic                 match_seen,
    output logic [$clog2(W)-1:0] match_ofs,
    output logic                 match_irq,
    output logic                 overrun
);
    localparam int OW = $clog2(W);
    localparam logic [OW-1:0] LAST = OW'(W - 1);

    rx_state_t     state, state_nx;
    logic [OW-1:0] bc;
    logic          act_in, step, hit, emit;

    assign act_in = rx_en & ~rx_reset;
    assign run    = act_in & (state != S_IDLE);
    assign step   = run & bit_en;
    assign hit    = step && (state == S_HUNT) && (cand == match_byte)
                    && (octet_only ? (ph == LAST) : full);
    assign emit   = hit || (step && (state == S_PASS) && (bc == LAST));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!act_in) begin
            state_nx = S_IDLE;                              // STOP
        end else begin
            unique case (state)
                S_IDLE:  state_nx = match_en ? S_HUNT : S_PASS; // START_HUNT / START_PASS
                S_HUNT:  state_nx = hit ? S_PASS : S_HUNT;      // MATCH
                S_PASS:  state_nx = S_PASS;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_data    <= '0;
            match_seen <= 1'b0;
            match_ofs  <= '0;
            match_irq  <= 1'b0;
            overrun    <= 1'b0;
            bc         <= '0;
        end else begin
            wr_en     <= 1'b0;
            match_irq <= 1'b0;
            if (rx_reset)               overrun <= 1'b0;
            else if (emit && fifo_full) overrun <= 1'b1;
            if (emit && !fifo_full) begin
                wr_en   <= 1'b1;
                wr_data <= cand;
            end
            if (!act_in) begin
                match_seen <= 1'b0;
                match_ofs  <= '0;
            end
            if (!run) begin
                bc <= '0;
            end else if (hit) begin
                match_seen <= 1'b1;
                match_ofs  <= ph;
                match_irq  <= irq_en;
                bc         <= '0;
            end else if (step && state == S_PASS) begin
                bc <= bc + 1'b1;
                if (!match_seen) begin
                    match_seen <= 1'b1;
                    match_ofs  <= '0;
                    match_irq  <= irq_en;
                end
            end
        end
    end

    AST_WR_ROOM:       assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(!fifo_full)); // R10
    AST_OVR_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) overrun && !rx_reset |=> overrun); // R10
    AST_WR_AFTER_SEEN: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> match_seen); // R5
    AST_HUNT_UNSEEN:   assert property (@(posedge clk) disable iff (!rst_n) (state == S_HUNT) |-> !match_seen); // R5
    AST_IRQ_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) match_irq |=> !match_irq); // R9
    AST_IRQ_RISE:      assert property (@(posedge clk) disable iff (!rst_n) match_irq |-> $rose(match_seen)); // R9
    AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> (!match_seen && !wr_en)); // R11
endmodule

// File: rtl/mrx_align_rx.sv
module mrx_align_rx #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 bit_in,
    input  logic                 rx_en,
    input  logic                 rx_reset,
    input  logic                 match_en,
    input  logic                 octet_only,
    input  logic [W-1:0]         match_byte,
    input  logic                 irq_en,
    input  logic                 fifo_full,
    output logic                 wr_en,
    output logic [W-1:0]         wr_data,
    output logic                 match_seen,
    output logic [$clog2(W)-1:0] match_ofs,
    output logic                 match_irq,
    output logic                 overrun
);
    localparam int OW = $clog2(W);

    logic [W-1:0]  cand;
    logic [OW-1:0] ph;
    logic          full;
    logic          run;

    mrx_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!run),
        .step   (run & bit_en),
        .bit_in (bit_in),
        .cand   (cand),
        .ph     (ph),
        .full   (full)
    );

    mrx_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_en      (rx_en),
        .rx_reset   (rx_reset),
        .match_en   (match_en),
        .octet_only (octet_only),
        .irq_en     (irq_en),
        .fifo_full  (fifo_full),
        .match_byte (match_byte),
        .cand       (cand),
        .ph         (ph),
        .full       (full),
        .run        (run),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .match_seen (match_seen),
        .match_ofs  (match_ofs),
        .match_irq  (match_irq),
        .overrun    (overrun)
    );
endmodule

// File: tb/tb_mrx_align_rx.sv
module tb_mrx_align_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0, rx_en = 1'b0, rx_reset = 1'b0;
    logic       match_en = 1'b0, octet_only = 1'b0, irq_en = 1'b0, fifo_full = 1'b0;
    logic [7:0] match_byte = 8'h00;
    logic       wr_en, match_seen, match_irq, overrun;
    logic [7:0] wr_data;
    logic [2:0] match_ofs;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mrx_align_rx #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .rx_en(rx_en), .rx_reset(rx_reset), .match_en(match_en),
        .octet_only(octet_only), .match_byte(match_byte), .irq_en(irq_en),
        .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data),
        .match_seen(match_seen), .match_ofs(match_ofs),
        .match_irq(match_irq), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int   m_st = 0;   // 0 off, 1 searching, 2 streaming
    int   m_k = 0;
    int   m_bc = 0;
    int   q[$];
    logic e_wr = 0, e_seen = 0, e_irq = 0, e_ovr = 0;
    logic [7:0] e_data = 0;
    logic [2:0] e_ofs = 0;

    task automatic m_emit(input int v);
        if (fifo_full) e_ovr = 1'b1;
        else begin e_wr = 1'b1; e_data = v[7:0]; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_k = 0; m_bc = 0; q.delete();
            e_wr = 0; e_seen = 0; e_irq = 0; e_ovr = 0; e_data = 0; e_ofs = 0;
        end else begin
            e_wr = 0; e_irq = 0;
            if (!(rx_en && !rx_reset)) begin
                m_st = 0; m_k = 0; m_bc = 0; q.delete();
                e_seen = 0; e_ofs = 0;
                if (rx_reset) e_ovr = 0;
            end else if (m_st == 0) begin
                m_st = match_en ? 1 : 2;
            end else if (bit_en) begin
                int cand;
                q.push_back(int'(bit_in));
                if (q.size() > 8) void'(q.pop_front());
                m_k++;
                cand = 0;
                for (int i = 0; i < q.size(); i++) cand |= q[i] << i;
                if (m_st == 2) begin
                    if (!e_seen) begin e_seen = 1; e_ofs = 0; e_irq = irq_en; end
                    m_bc++;
                    if (m_bc == 8) begin m_emit(cand); m_bc = 0; end
                end else if (q.size() == 8 && cand == int'(match_byte) &&
                             (!octet_only || (m_k % 8) == 0)) begin
                    m_emit(cand);
                    e_seen = 1; e_ofs = 3'((m_k - 1) % 8); e_irq = irq_en;
                    m_st = 2; m_bc = 0;
                end
            end
        end
    end

    logic [7:0] got[$];
    int irq_cnt = 0;

    // every-clock comparison and capture, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(wr_en == e_wr, "R5 write strobe", int'(wr_en), int'(e_wr));
            if (e_wr) chk(wr_data == e_data, "R1 byte value", int'(wr_data), int'(e_data));
            chk(match_seen == e_seen, "R7 match_seen", int'(match_seen), int'(e_seen));
            if (e_seen) chk(match_ofs == e_ofs, "R8 offset", int'(match_ofs), int'(e_ofs));
            chk(match_irq == e_irq, "R9 irq", int'(match_irq), int'(e_irq));
            chk(overrun == e_ovr, "R10 overrun", int'(overrun), int'(e_ovr));
            if (wr_en) got.push_back(wr_data);
            if (match_irq) irq_cnt++;
        end
    end

    task automatic send_bit(input logic b);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic reset_rx();
        got.delete(); irq_cnt = 0;
        rx_reset = 1'b1;
        @(negedge clk);
        rx_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !match_seen && !overrun && !match_irq && match_ofs == 0,
            "R11 reset state", int'(match_seen), 0);

        // free-running, LSB first
        irq_en = 1; match_en = 0; rx_en = 1;
        @(negedge clk);
        send_byte(8'hA5); send_byte(8'h3C); settle();
        chk(got.size() == 2, "R2 byte count", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'hA5, "R1 first byte", int'(got[0]), 'hA5);
            chk(got[1] == 8'h3C, "R2 second byte", int'(got[1]), 'h3C);
        end
        chk(match_seen && match_ofs == 0, "R7 seen/offset", int'(match_ofs), 0);
        chk(irq_cnt == 1, "R9 irq count", irq_cnt, 1);

        // sliding search, match three bits off the boundary
        match_en = 1; octet_only = 0; match_byte = 8'h7E;
        reset_rx();
        chk(!match_seen, "R6 seen cleared", int'(match_seen), 0);
        send_bit(0); send_bit(0); send_bit(0);
        chk(got.size() == 0, "R5 nothing before match", got.size(), 0);
        send_byte(8'h7E); send_byte(8'h12); settle();
        chk(got.size() == 2, "R3 byte count", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'h7E, "R5 match byte first", int'(got[0]), 'h7E);
            chk(got[1] == 8'h12, "R3 aligned follower", int'(got[1]), 'h12);
        end
        chk(match_ofs == 3'd2, "R8 sliding offset", int'(match_ofs), 2);

        // octet-only search refuses the misaligned copy
        octet_only = 1;
        reset_rx();
        send_bit(0); send_bit(0); send_bit(0);
        send_byte(8'h7E);
        for (int i = 0; i < 5; i++) send_bit(0);
        send_byte(8'h7E); send_byte(8'h55); settle();
        chk(got.size() == 2, "R4 byte count", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'h7E, "R4 match byte", int'(got[0]), 'h7E);
            chk(got[1] == 8'h55, "R4 follower", int'(got[1]), 'h55);
        end
        chk(match_ofs == 3'd7, "R8 aligned offset", int'(match_ofs), 7);

        // interrupt disabled
        irq_en = 0; octet_only = 0;
        reset_rx();
        send_byte(8'h7E); settle();
        chk(match_seen && match_ofs == 3'd7, "R8 immediate match", int'(match_ofs), 7);
        chk(irq_cnt == 0, "R9 irq masked", irq_cnt, 0);

        // overrun
        irq_en = 1; match_en = 0;
        reset_rx();
        fifo_full = 1;
        send_byte(8'h11);
        fifo_full = 0;
        send_byte(8'h22); settle();
        chk(got.size() == 1, "R10 dropped byte", got.size(), 1);
        if (got.size() == 1) chk(got[0] == 8'h22, "R10 kept byte", int'(got[0]), 'h22);
        chk(overrun, "R10 sticky", int'(overrun), 1);
        reset_rx();
        chk(!overrun, "R6 overrun cleared", int'(overrun), 0);

        // receiver disabled
        rx_en = 0;
        @(negedge clk);
        got.delete();
        chk(!match_seen, "R11 seen low when off", int'(match_seen), 0);
        send_byte(8'hFF); settle();
        chk(got.size() == 0, "R11 strobes ignored", got.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule